// File: doc/BRIEF.md
# Presettable Down Counter with Terminal Count

A binary down counter that steps on the rising clock edge. It has four active-low controls. The strongest is an asynchronous clear, which forces the all-ones count. Next comes an asynchronous load, which forces the count to a parallel input word. A synchronous load captures that word on the next clock edge. The last control is an enable: while it is low the counter steps down by one per edge. Once the count reaches zero it wraps to all-ones, so a free-running counter cycles through 2^W states.

An active-low terminal-count flag is decoded without a register. It is low when the count is zero and the enable is low. Stages are chained by driving the enable of the next stage from the flag of the stage before it. The usual uses are programmable timers and divide-by-N clock chains: load N, count to zero, and reload or wrap.

Top module: `preset_down_counter`

## Requirements
- R1: While `clr_n` is low, `count` reads all-ones (255 for W=8) at once, whatever the clock and every other control are doing.
- R2: While `clr_n` is high and `aload_n` is low, `count` equals `jam` at once and follows changes on `jam` without a clock edge. `sload_n`, `en_n` and the clock have no effect during this time.
- R3: With both asynchronous controls high, a rising edge with `sload_n` low loads `jam` into `count`, even if `en_n` is high or low. `jam` is an unsigned value with bit W-1 as the most significant bit, so loading 8'h80 reads back as 128.
- R4: With `clr_n`, `aload_n` and `sload_n` high and `en_n` low, each rising edge lowers `count` by exactly one.
- R5: With `clr_n`, `aload_n` and `sload_n` high and `en_n` high, `count` keeps its value across rising edges.
- R6: Counting down from zero wraps to all-ones, so a free-running counter comes back to the same value after 256 edges.
- R7: `tc_n` is low exactly when `count` is zero and `en_n` is low. A change on `en_n` reaches `tc_n` without a clock edge.
- R8: When an asynchronous control is released, the count holds the forced value. If `jam` has not changed since the last edge, the first rising edge after the release acts on the synchronous controls. This holds when the release comes just before that edge and when it comes just after the previous edge.
- R9: When a second stage has its `en_n` driven by the `tc_n` of a first stage, the second stage steps down once each time the first stage passes through zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| clr_n | input | 1 | Asynchronous clear to all-ones, active low, highest priority |
| aload_n | input | 1 | Asynchronous load of `jam`, active low |
| sload_n | input | 1 | Synchronous load of `jam` on the next edge, active low |
| en_n | input | 1 | Count enable, active low; also gates `tc_n` |
| jam | input | W | Parallel load word, bit W-1 most significant |
| count | output | W | Present count value |
| tc_n | output | 1 | Terminal count, active low, combinational |

## Verification
The bench builds two instances at the default width W=8. The first is the stage under test. The second is an upper stage whose enable is the first stage's terminal-count flag. At this width a full wrap takes only 256 edges, so the complete cycle length and two carries into the upper stage fit in a short run. The asynchronous clear and load are applied and released in the middle of a cycle, just before an edge and just after one. This makes the point where asynchronous priority gives way to the synchronous controls observable at the ports.

// File: rtl/dcnt_pkg.sv
`timescale 1ns/1ps
package dcnt_pkg;
    // What the next rising edge does to the count when no asynchronous control is active.
    typedef enum logic [1:0] {
        STEP_HOLD = 2'd0,
        STEP_DEC  = 2'd1,
        STEP_LOAD = 2'd2
    } step_e;
endpackage

// File: rtl/dcnt_next.sv
`timescale 1ns/1ps
module dcnt_next #(
    parameter int W = 8
) (
    input  logic [W-1:0]      cur_q,
    input  logic [W-1:0]      jam_i,
    input  logic              sload_n_i,
    input  logic              en_n_i,
    output logic [W-1:0]      nxt_d,
    output dcnt_pkg::step_e   step_o
);
    import dcnt_pkg::*;

    localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

    typedef struct packed {
        step_e        step;
        logic [W-1:0] cnt;
    } nxt_t;

    nxt_t nxt_d_s;

    always_comb begin
        nxt_d_s = '{step: STEP_HOLD, cnt: cur_q};
        if (!sload_n_i) begin
            nxt_d_s.step = STEP_LOAD;
        end else if (!en_n_i) begin
            nxt_d_s.step = STEP_DEC;
        end
        case (nxt_d_s.step)
            STEP_LOAD: nxt_d_s.cnt = jam_i;
            STEP_DEC:  nxt_d_s.cnt = cur_q - ONE; // zero wraps to all-ones
            default:   nxt_d_s.cnt = cur_q;
        endcase
    end

    assign nxt_d  = nxt_d_s.cnt;
    assign step_o = nxt_d_s.step;
endmodule

// File: rtl/dcnt_reg.sv
`timescale 1ns/1ps
module dcnt_reg #(
    parameter int W = 8
) (
    input  logic         clk_i,
    input  logic         clr_n_i,
    input  logic         aload_n_i,
    input  logic [W-1:0] jam_i,
    input  logic [W-1:0] cnt_d,
    output logic [W-1:0] cnt_q
);
    localparam logic [W-1:0] TOP = {W{1'b1}};

    // Clear beats load; each edge taken while load is held recaptures the word.
    always_ff @(posedge clk_i or negedge clr_n_i or negedge aload_n_i) begin
        if (!clr_n_i) begin
            cnt_q <= TOP;
        end else if (!aload_n_i) begin
            cnt_q <= jam_i;
        end else begin
            cnt_q <= cnt_d;
        end
    end
endmodule

// File: rtl/dcnt_term.sv
`timescale 1ns/1ps
module dcnt_term #(
    parameter int W = 8
) (
    input  logic [W-1:0] cnt_i,
    input  logic         en_n_i,
    output logic         tc_n_o
);
    logic [W:0] seen_one;

    assign seen_one[0] = 1'b0;
    for (genvar g = 0; g < W; g++) begin : g_zero_chain
        assign seen_one[g+1] = seen_one[g] | cnt_i[g];
    end

    assign tc_n_o = seen_one[W] | en_n_i;
endmodule

// File: rtl/preset_down_counter.sv
`timescale 1ns/1ps
module preset_down_counter #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         clr_n,
    input  logic         aload_n,
    input  logic         sload_n,
    input  logic         en_n,
    input  logic [W-1:0] jam,
    output logic [W-1:0] count,
    output logic         tc_n
);
    import dcnt_pkg::*;

    localparam logic [W-1:0] TOP = {W{1'b1}};
    localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

    logic [W-1:0] cnt_d;
    logic [W-1:0] cnt_q;
    step_e        step;

    dcnt_next #(.W(W)) u_next (
        .cur_q     (cnt_q),
        .jam_i     (jam),
        .sload_n_i (sload_n),
        .en_n_i    (en_n),
        .nxt_d     (cnt_d),
        .step_o    (step)
    );

    dcnt_reg #(.W(W)) u_reg (
        .clk_i     (clk),
        .clr_n_i   (clr_n),
        .aload_n_i (aload_n),
        .jam_i     (jam),
        .cnt_d     (cnt_d),
        .cnt_q     (cnt_q)
    );

    // A held asynchronous load shows the live word without waiting for an edge.
    assign count = (clr_n && !aload_n) ? jam : cnt_q;

    dcnt_term #(.W(W)) u_term (
        .cnt_i  (count),
        .en_n_i (en_n),
        .tc_n_o (tc_n)
    );

    // Asynchronous overrides, sampled mid-cycle.
    always @(negedge clk) begin
        if (!clr_n) begin
            p_clear_r1: assert (count == TOP)
                else $error("clear did not force all-ones");
        end else if (!aload_n) begin
            p_aload_r2: assert (count == jam)
                else $error("async load not transparent");
        end
    end

    p_sload_r3: assert property (@(posedge clk) disable iff (!clr_n || !aload_n)
        (step == STEP_LOAD) |=> (count == $past(jam)))
        else $error("sync load missed");

    p_dec_r4: assert property (@(posedge clk) disable iff (!clr_n || !aload_n)
        (sload_n && !en_n && count != '0) |=> (count == $past(count) - ONE))
        else $error("decrement wrong");

    p_hold_r5: assert property (@(posedge clk) disable iff (!clr_n || !aload_n)
        (sload_n && en_n) |=> $stable(count))
        else $error("count moved while inhibited");

    p_wrap_r6: assert property (@(posedge clk) disable iff (!clr_n || !aload_n)
        (sload_n && !en_n && count == '0) |=> (count == TOP))
        else $error("zero did not wrap");

    p_tc_r7: assert property (@(posedge clk) disable iff (!clr_n || !aload_n)
        (!tc_n && sload_n) |=> (count == TOP))
        else $error("terminal flag not followed by wrap");
endmodule

// File: tb/preset_down_counter_test.sv
`timescale 1ns/1ps
module preset_down_counter_test;
    localparam int W = 8;
    localparam int MASK = (1 << W) - 1;

    logic clk = 1'b0;
    logic clr_n = 1'b1;
    logic aload_n = 1'b1;
    logic sload_n = 1'b1;
    logic en_n = 1'b1;
    logic [W-1:0] jam = '0;
    logic [W-1:0] count;
    logic tc_n;
    logic [W-1:0] up_count;
    logic up_tc_n;

    int checks = 0;
    int fails = 0;
    int m_lo = MASK;
    int m_up = MASK;
    bit run = 1'b0;
    string tag = "R1";

    always #2.5 clk = ~clk;

    preset_down_counter #(.W(W)) uut (
        .clk(clk), .clr_n(clr_n), .aload_n(aload_n), .sload_n(sload_n),
        .en_n(en_n), .jam(jam), .count(count), .tc_n(tc_n)
    );

    // Second stage chained on the first stage's terminal flag (R9).
    preset_down_counter #(.W(W)) upper (
        .clk(clk), .clr_n(clr_n), .aload_n(1'b1), .sload_n(1'b1),
        .en_n(tc_n), .jam('0), .count(up_count), .tc_n(up_tc_n)
    );

    function automatic int vis_lo();
        if (!clr_n) return MASK;
        if (!aload_n) return int'(jam);
        return m_lo;
    endfunction

    function automatic int exp_tc();
        return (vis_lo() == 0 && !en_n) ? 0 : 1;
    endfunction

    task automatic chk(input string t, input string what, input int got, input int exp);
        checks++;
        if (got != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d at %0t", t, what, got, exp, $time);
        end
    endtask

    // Reference model: priority clear > async load > sync load > count.
    always @(posedge clk) begin
        if (run) begin
            if (!clr_n) m_up = MASK;
            else if (exp_tc() == 0) m_up = (m_up - 1) & MASK;
            if (!clr_n) m_lo = MASK;
            else if (!aload_n) m_lo = int'(jam);
            else if (!sload_n) m_lo = int'(jam);
            else if (!en_n) m_lo = (m_lo - 1) & MASK;
        end
    end

    always @(negedge clk) begin
        if (run) begin
            if (!clr_n) begin m_lo = MASK; m_up = MASK; end
            else if (!aload_n) m_lo = int'(jam);
            chk(tag, "count", int'(count), vis_lo());
            chk("R7", "tc_n", int'(tc_n), exp_tc());
            chk("R9", "upper count", int'(up_count), m_up);
        end
    end

    task automatic step(input int n);
        repeat (n) begin @(posedge clk); #1; end
    endtask

    initial begin
        #(200000 * 5);
        fails++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        #1 clr_n = 1'b0;
        run = 1'b1;
        step(3);
        tag = "R1";
        chk("R1", "reset count", int'(count), 255);
        chk("R7", "reset tc_n", int'(tc_n), 1);

        clr_n = 1'b1; tag = "R5";
        step(4);
        chk("R5", "hold", int'(count), 255);

        tag = "R3"; jam = 8'h80; sload_n = 1'b0;
        step(1);
        sload_n = 1'b1;
        chk("R3", "load 0x80 msb", int'(count), 128);
        tag = "R4"; en_n = 1'b0;
        step(5);
        chk("R4", "five decrements", int'(count), 8'h7B);

        tag = "R3"; jam = 8'h05; sload_n = 1'b0;
        step(1);
        sload_n = 1'b1;
        chk("R3", "load over count", int'(count), 5);

        tag = "R6";
        step(5);
        chk("R6", "reached zero", int'(count), 0);
        chk("R7", "tc at zero", int'(tc_n), 0);
        #0.3 en_n = 1'b1;
        #0.2 chk("R7", "tc follows enable", int'(tc_n), 1);
        #0.2 en_n = 1'b0;
        #0.2 chk("R7", "tc low again", int'(tc_n), 0);
        step(1);
        chk("R6", "wrap", int'(count), 255);

        tag = "R9";
        step(256);
        chk("R6", "256-edge cycle", int'(count), 255);
        step(256);
        chk("R9", "upper after carries", int'(up_count), 252);

        tag = "R2";
        aload_n = 1'b0; jam = 8'h3C; sload_n = 1'b0;
        #0.5 chk("R2", "async load immediate", int'(count), 8'h3C);
        #0.2 jam = 8'hA5;
        #0.2 chk("R2", "async transparent", int'(count), 8'hA5);
        step(1);
        sload_n = 1'b1; en_n = 1'b0;
        step(1);
        chk("R2", "clock ignored", int'(count), 8'hA5);
        @(posedge clk); #4.8 aload_n = 1'b1; tag = "R8";
        @(posedge clk); #1;
        chk("R8", "release before edge", int'(count), 8'hA4);

        aload_n = 1'b0; jam = 8'h10; tag = "R2";
        step(2);
        @(posedge clk); #0.2 aload_n = 1'b1; tag = "R8";
        #0.8 chk("R8", "release after edge", int'(count), 8'h10);
        step(1);
        chk("R8", "first count after release", int'(count), 8'h0F);

        aload_n = 1'b0; jam = 8'h55; tag = "R1";
        #0.2 clr_n = 1'b0;
        #0.3 chk("R1", "clear beats load", int'(count), 255);
        step(1);
        chk("R1", "clear held", int'(count), 255);
        @(posedge clk); #4.8 clr_n = 1'b1; tag = "R2";
        #0.1 chk("R2", "load after clear release", int'(count), 8'h55);
        @(posedge clk); #0.2 aload_n = 1'b1; tag = "R8";
        #0.8 chk("R8", "held word kept", int'(count), 8'h55);
        step(1);
        chk("R8", "count resumes", int'(count), 8'h54);

        tag = "R1"; clr_n = 1'b0;
        step(2);
        @(posedge clk); #4.8 clr_n = 1'b1; tag = "R8";
        @(posedge clk); #1;
        chk("R8", "clear release before edge", int'(count), 254);
        step(3);

        run = 1'b0;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule